// File: doc/BRIEF.md
# Multiplexed Bank Byte Capture and Phase-Gated Bus Front End

This block sits between a processor that drives only sixteen address lines and a system bus that needs a full 24-bit address. In the low half of every bus cycle, the processor puts the upper address byte on its data pins. The block keeps that byte and joins it to the sixteen address lines to form the system address. In the high half of the cycle, the data pins carry real data. The block then switches a two-way data path between the processor and the system data bus. It only does so when the phase clock is high, so devices on the system bus never see the bank byte as data.

The block also decodes the 24-bit address into three chip selects: I/O, main RAM and expansion RAM. From these it forms active-low read and write strobes for devices that take separate read and write enables. The phase clock is sampled by a fast system clock. Each tristate net is modelled as three signals: an input value, an output value and a drive enable.

Top module: `bank_demux_gate`

## Requirements
- R1: While the sampled phase clock is low, the block records the processor data pins on every system clock. At the first system clock edge that samples the phase clock high, the last recorded value becomes address bits 23:16. It is visible from that edge until the next such edge.
- R2: Throughout the high phase, address bits 23:16 stay unchanged, even while the data pins change.
- R3: `sys_d_oe` is high only when all of these hold: the registered phase is high, `vda` or `vpa` is high, and `rw` is 0. While it is high, `sys_d_out` equals `cpu_d_in`.
- R4: `cpu_d_oe` is high only when all of these hold: the registered phase is high, `vda` or `vpa` is high, and `rw` is 1. While it is high, `cpu_d_out` equals `sys_d_in`.
- R5: When `vda` and `vpa` are both low, none of `cs_io`, `cs_ram` or `cs_xram` is asserted.
- R6: With a valid address, the chip selects decode as follows. Addresses 0x00C000 through 0x00CFFF assert `cs_io`. Every other bank-0x00 address asserts `cs_ram`. Any non-zero bank asserts `cs_xram`. At most one chip select is high at a time.
- R7: `rd_n` is low only when all of these hold: `rw` is 1, the registered phase is high, and a chip select is asserted.
- R8: `wr_n` is low only when all of these hold: `rw` is 0, the registered phase is high, and a chip select is asserted.
- R9: On every system clock after an edge that sampled the phase clock low, these outputs are inactive: `rd_n`, `wr_n`, `sys_d_oe` and `cpu_d_oe`.
- R10: During reset and afterwards, all strobes and both drive enables are inactive. Address bits 23:16 read zero until the first low phase has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the phase clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phi2 | input | 1 | Processor phase clock; low half carries the bank byte |
| rw | input | 1 | 1 = read, 0 = write |
| vda | input | 1 | Processor marks a valid data address |
| vpa | input | 1 | Processor marks a valid program address |
| cpu_addr | input | 16 | Processor address lines |
| cpu_d_in | input | 8 | Value on processor data pins (bank byte or write data) |
| cpu_d_out | output | 8 | Value driven toward processor data pins on a read |
| cpu_d_oe | output | 1 | Drive enable toward the processor |
| sys_d_in | input | 8 | Value present on the system data bus |
| sys_d_out | output | 8 | Value driven onto the system data bus on a write |
| sys_d_oe | output | 1 | Drive enable onto the system data bus |
| sys_addr | output | 24 | Bank byte joined with processor address |
| cs_io | output | 1 | I/O device select |
| cs_ram | output | 1 | Bank-0 RAM select |
| cs_xram | output | 1 | Expansion RAM select |
| rd_n | output | 1 | Active-low read enable |
| wr_n | output | 1 | Active-low write enable |

## Verification
The bench changes the data pins once more late in each low phase, so the byte that is kept must be the last one and not the first. A design that grabs the byte too early, or keeps following the pins in the high phase, shows a wrong bank or a bank that drifts while the pins change. It steps across the I/O window edges at 0x00BFFF, 0x00C000, 0x00CFFF and 0x00D000, and it uses a non-zero bank, where an off-by-one decode or a decode that ignores the bank picks the wrong select. Cycles with both valid flags low, and cycles with only the program flag high, show whether a design forgets the qualifier or treats only one flag as valid. In every low cycle the strobes and enables are checked, which catches any gating that uses the raw pins or leaves the data path driving during the bank half.

// File: rtl/bank_demux_gate.sv
module bank_demux_gate #(
  parameter int AW = 16,
  parameter int BW = 8,
  parameter logic [AW-1:0] IO_BASE = 16'hC000,
  parameter int IO_SPAN_BITS = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           phi2,
  input  logic           rw,
  input  logic           vda,
  input  logic           vpa,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [BW-1:0]  cpu_d_in,
  output logic [BW-1:0]  cpu_d_out,
  output logic           cpu_d_oe,
  input  logic [BW-1:0]  sys_d_in,
  output logic [BW-1:0]  sys_d_out,
  output logic           sys_d_oe,
  output logic [AW+BW-1:0] sys_addr,
  output logic           cs_io,
  output logic           cs_ram,
  output logic           cs_xram,
  output logic           rd_n,
  output logic           wr_n
);
  localparam int TAG_W = AW - IO_SPAN_BITS;

  logic          phase_q;
  logic [BW-1:0] shadow_q;
  logic [BW-1:0] bank_q;
  logic          addr_ok;
  logic          any_cs;
  logic          rise;

  assign rise = phi2 & ~phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= 1'b0;
      shadow_q <= '0;
      bank_q   <= '0;
    end else begin
      phase_q <= phi2;
      if (!phi2) shadow_q <= cpu_d_in;
      if (rise)  bank_q   <= shadow_q;
    end
  end

  assign sys_addr = {bank_q, cpu_addr};
  assign addr_ok  = vda | vpa;

  assign cs_io   = addr_ok && (bank_q == '0) &&
                   (cpu_addr[AW-1 -: TAG_W] == IO_BASE[AW-1 -: TAG_W]);
  assign cs_ram  = addr_ok && (bank_q == '0) && !cs_io;
  assign cs_xram = addr_ok && (bank_q != '0);
  assign any_cs  = cs_io | cs_ram | cs_xram;

  assign rd_n = ~(phase_q &  rw & any_cs);
  assign wr_n = ~(phase_q & ~rw & any_cs);

  assign sys_d_oe  = phase_q & addr_ok & ~rw;
  assign sys_d_out = cpu_d_in;
  assign cpu_d_oe  = phase_q & addr_ok &  rw;
  assign cpu_d_out = sys_d_in;
endmodule

// File: rtl/bank_demux_gate_chk.sv
module bank_demux_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        phi2,
  input logic        rw,
  input logic        vda,
  input logic        vpa,
  input logic [7:0]  cpu_d_in,
  input logic [7:0]  sys_d_in,
  input logic [7:0]  cpu_d_out,
  input logic        cpu_d_oe,
  input logic [7:0]  sys_d_out,
  input logic        sys_d_oe,
  input logic [23:0] sys_addr,
  input logic        cs_io,
  input logic        cs_ram,
  input logic        cs_xram,
  input logic        rd_n,
  input logic        wr_n
);
  a_r9_quiet_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(phi2) && $past(rst_n)) |-> (rd_n && wr_n && !sys_d_oe && !cpu_d_oe));

  a_r1_bank_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(phi2) && phi2) |=> (sys_addr[23:16] == $past(cpu_d_in, 2)));

  a_r2_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phi2) && phi2) |=> $stable(sys_addr[23:16]));

  a_r5_no_cs_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !(vda || vpa) |-> !(cs_io || cs_ram || cs_xram));

  a_r6_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_io, cs_ram, cs_xram}));

  a_r7_read_qual: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (rw && (cs_io || cs_ram || cs_xram)));

  a_r8_write_qual: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (!rw && (cs_io || cs_ram || cs_xram)));

  a_r3_sys_drive: assert property (@(posedge clk) disable iff (!rst_n)
    sys_d_oe |-> (!rw && (vda || vpa) && sys_d_out == cpu_d_in));

  a_r4_cpu_drive: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_d_oe |-> (rw && (vda || vpa) && cpu_d_out == sys_d_in));
endmodule

bind bank_demux_gate bank_demux_gate_chk chk_i (
  .clk(clk), .rst_n(rst_n), .phi2(phi2), .rw(rw), .vda(vda), .vpa(vpa),
  .cpu_d_in(cpu_d_in), .sys_d_in(sys_d_in), .cpu_d_out(cpu_d_out),
  .cpu_d_oe(cpu_d_oe), .sys_d_out(sys_d_out), .sys_d_oe(sys_d_oe),
  .sys_addr(sys_addr), .cs_io(cs_io), .cs_ram(cs_ram), .cs_xram(cs_xram),
  .rd_n(rd_n), .wr_n(wr_n)
);

// File: tb/bank_demux_gate_tb.sv
module bank_demux_gate_tb_top;
  logic clk = 1'b0;
  logic rst_n, phi2, rw, vda, vpa;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_d_in, sys_d_in, cpu_d_out, sys_d_out;
  logic        cpu_d_oe, sys_d_oe, cs_io, cs_ram, cs_xram, rd_n, wr_n;
  logic [23:0] sys_addr;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bank_demux_gate dut_i (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .rw(rw), .vda(vda), .vpa(vpa),
    .cpu_addr(cpu_addr), .cpu_d_in(cpu_d_in), .cpu_d_out(cpu_d_out),
    .cpu_d_oe(cpu_d_oe), .sys_d_in(sys_d_in), .sys_d_out(sys_d_out),
    .sys_d_oe(sys_d_oe), .sys_addr(sys_addr), .cs_io(cs_io),
    .cs_ram(cs_ram), .cs_xram(cs_xram), .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_quiet(input string tag);
    chk({"R9 quiet ", tag}, {rd_n, wr_n, sys_d_oe, cpu_d_oe}, 4'b1100);
  endtask

  // One bus cycle: low phase with a decoy then the bank byte, then high phase.
  task automatic bus_cycle(input logic [7:0] bank, input logic [15:0] a,
                           input logic r, input logic v1, input logic v2,
                           input logic [7:0] wdat, input logic [7:0] sdat,
                           input string tag);
    logic ok, io, ram, xr, anycs;
    ok  = v1 | v2;
    io  = ok && bank == 8'h00 && a[15:12] == 4'hC;
    ram = ok && bank == 8'h00 && !io;
    xr  = ok && bank != 8'h00;
    anycs = io | ram | xr;
    @(negedge clk);
    phi2 = 1'b0; cpu_addr = a; rw = r; vda = v1; vpa = v2;
    cpu_d_in = ~bank; sys_d_in = sdat;
    @(negedge clk); check_quiet(tag);
    cpu_d_in = bank;
    @(negedge clk); check_quiet(tag);
    phi2 = 1'b1;
    cpu_d_in = r ? 8'hEE : wdat;
    @(negedge clk);
    chk({"R1 addr ", tag}, 32'(sys_addr), 32'({bank, a}));
    chk({"R6 selects ", tag}, {cs_io, cs_ram, cs_xram}, {io, ram, xr});
    chk({"R5 valid ", tag}, 32'(cs_io | cs_ram | cs_xram), 32'(anycs));
    chk({"R7 rd_n ", tag}, 32'(rd_n), 32'(!(r && anycs)));
    chk({"R8 wr_n ", tag}, 32'(wr_n), 32'(!(!r && anycs)));
    chk({"R3 sys oe ", tag}, 32'(sys_d_oe), 32'(ok && !r));
    chk({"R4 cpu oe ", tag}, 32'(cpu_d_oe), 32'(ok && r));
    if (ok && !r) chk({"R3 sys data ", tag}, 32'(sys_d_out), 32'(wdat));
    if (ok && r)  chk({"R4 cpu data ", tag}, 32'(cpu_d_out), 32'(sdat));
    cpu_d_in = ~cpu_d_in;
    @(negedge clk);
    chk({"R2 hold ", tag}, 32'(sys_addr[23:16]), 32'(bank));
    cpu_d_in = 8'h00;
    @(negedge clk);
    chk({"R2 hold2 ", tag}, 32'(sys_addr[23:16]), 32'(bank));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; phi2 = 1'b0; rw = 1'b1; vda = 1'b0; vpa = 1'b0;
    cpu_addr = 16'h0000; cpu_d_in = 8'hAB; sys_d_in = 8'h00;
    repeat (3) @(negedge clk);
    chk("R10 reset strobes", {rd_n, wr_n, sys_d_oe, cpu_d_oe}, 4'b1100);
    chk("R10 reset bank", 32'(sys_addr[23:16]), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 bank during first low", 32'(sys_addr[23:16]), 32'h0);
    check_quiet("after reset");
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    bus_cycle(8'h00, 16'hC123, 1'b1, 1'b1, 1'b0, 8'h00, 8'h3C, "io read");
    bus_cycle(8'h00, 16'h1234, 1'b0, 1'b1, 1'b0, 8'hA5, 8'h00, "ram write");
    bus_cycle(8'h7F, 16'hC010, 1'b1, 1'b0, 1'b1, 8'h00, 8'h96, "xram read vpa");
    bus_cycle(8'h01, 16'h0000, 1'b0, 1'b1, 1'b1, 8'h5A, 8'h00, "xram write");
    bus_cycle(8'h42, 16'hC000, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22, "invalid write");
    bus_cycle(8'h00, 16'hC000, 1'b1, 1'b0, 1'b0, 8'h00, 8'h77, "invalid read");
    bus_cycle(8'h00, 16'hBFFF, 1'b1, 1'b1, 1'b0, 8'h00, 8'h01, "edge BFFF");
    bus_cycle(8'h00, 16'hC000, 1'b0, 1'b1, 1'b0, 8'hC3, 8'h00, "edge C000");
    bus_cycle(8'h00, 16'hCFFF, 1'b1, 1'b1, 1'b0, 8'h00, 8'hF0, "edge CFFF");
    bus_cycle(8'h00, 16'hD000, 1'b0, 1'b0, 1'b1, 8'h0F, 8'h00, "edge D000");
    bus_cycle(8'hFF, 16'hFFFF, 1'b1, 1'b1, 1'b0, 8'h00, 8'h81, "bank FF");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule